// File: doc/BRIEF.md
# Serial Two-Channel SAR Converter Controller

This block is the digital control core of a two-input, 12-bit successive-approximation converter. An active-low chip select frames each exchange. The block is clocked by the serial clock itself. The serial input is sampled on rising edges, and the serial output changes on falling edges. Once chip select is low, the block waits for the first one on the serial input. It then takes four configuration bits: single-ended versus differential, channel or polarity, output order, and power-down request.

From the configuration bits the block drives the analog multiplexer selects and the sample/hold control. It then walks a binary search over a 12-bit DAC code, one decision per clock, against an external comparator. Each decided bit is sent out on the serial line on the next falling edge. After the last bit the output either holds zero or replays the word LSB first. A power-down request replaces the word with twelve ones and raises a power-down flag.

The finished code also appears on a parallel port together with a single-cycle valid pulse. There is no ready signal, so that port cannot apply back-pressure: the consumer must take the word in the cycle the pulse is high. Edge numbers in the requirements count rising and falling serial-clock edges, where edge 1 is the one that samples the start bit.

Top module: `adc_sar_ctl`

## Requirements
- R1: Zeros on `din` after chip select falls are ignored. The first one sampled on a rising edge is the start bit (edge 1), however many zeros come before it.
- R2: Rising edges 2 to 5 capture four bits in the order single-ended flag, odd/polarity flag, MSB-first flag, power-up flag. After that, `din` has no effect on the output stream or the result until chip select rises.
- R3: The multiplexer encoding is as follows. `mux_minus_gnd_o` equals the single-ended flag: 1 means the minus input is ground, 0 means it is the other channel. `mux_plus_sel_o` equals the odd flag: 0 selects channel 0 as plus, 1 selects channel 1. Both are valid, with `mux_en_o` high, from rising edge 3, and they stay constant while the output is driven.
- R4: `sample_o` rises on rising edge 3 and falls on falling edge 5, a window of 2.5 clocks. It is never high while the output is enabled.
- R5: `dout_oe_o` stays low until falling edge 5. At that edge it rises and `dout_o` carries a single zero null bit.
- R6: On falling edges 6 to 17, `dout_o` carries the code B11 down to B0. The code equals floor(Vin*4096/Vref), clamped to the range 0 to 4095. Each bit is set when the comparator reports input at or above the trial DAC level.
- R7: With the MSB-first flag at 1, `dout_o` is 0 from falling edge 18 until chip select rises.
- R8: With the MSB-first flag at 0, falling edges 18 to 28 carry B1 through B11, and the output is 0 after that.
- R9: With the power-up flag at 0, the stream carries twelve ones followed by zeros, and no result pulse is produced. `power_down_o` rises on rising edge 5 and stays high while chip select is high. It clears on the first rising edge of the next frame, and that frame converts normally.
- R10: A rising chip select immediately drops `dout_oe_o` and resets the protocol at any point in a frame.
- R11: `res_valid_o` is high for exactly one cycle, after rising edge 17, with `result_o` equal to the code sent serially.
- R12: While `rst_n` is low, `dout_oe_o`, `sample_o`, `mux_en_o`, `res_valid_o` and `power_down_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing each exchange |
| din | input | 1 | Serial configuration input, sampled on rising edges |
| comp_i | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| dout_o | output | 1 | Serial result data, changes on falling edges |
| dout_oe_o | output | 1 | Output enable for the serial data pad |
| sample_o | output | 1 | 1 = track the plus input, 0 = hold |
| mux_en_o | output | 1 | Multiplexer selects are valid |
| mux_plus_sel_o | output | 1 | Channel routed to the plus input (0 or 1) |
| mux_minus_gnd_o | output | 1 | 1 = minus input tied to ground |
| dac_o | output | NB | Trial code for the DAC |
| result_o | output | NB | Parallel result word |
| res_valid_o | output | 1 | One-cycle strobe for result_o |
| power_down_o | output | 1 | Analog power-down request |

## Verification
The conversion is run with mid-scale, full-scale, arbitrary single-ended and negative differential inputs, on both channels and in both polarities. This separates mux-decode errors, comparator-sense errors and clamping errors. Frames are sent with different numbers of leading zeros, to expose start detection that is off by one edge. Trailing input is sent both as a toggle and as constant ones, to expose any reopening of the configuration capture. The two output orders, a shutdown frame followed by a normal frame, and a frame aborted mid-conversion tell apart the tail, replay, power-down persistence and protocol-reset behaviour.

// File: rtl/adc_ctl_pkg.sv
`timescale 1ns/1ps
package adc_ctl_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CFG  = 2'd1,
    ST_DONE = 2'd2
  } rx_state_e;

  // positions of the configuration fields in the capture register
  localparam int F_SGL  = 0;
  localparam int F_ODD  = 1;
  localparam int F_MSBF = 2;
  localparam int F_PUP  = 3;
  localparam int CFG_W  = 4;
endpackage

// File: rtl/adc_cfg_rx.sv
`timescale 1ns/1ps
module adc_cfg_rx
  import adc_ctl_pkg::*;
(
  input  logic sclk,
  input  logic clr,
  input  logic rst_n,
  input  logic cs_n,
  input  logic din,
  output logic cfg_done,
  output logic mux_valid,
  output logic sgl,
  output logic odd,
  output logic msbf,
  output logic pup,
  output logic pd
);
  localparam int IW = $clog2(CFG_W);

  rx_state_e         st_q;
  logic [IW-1:0]     idx_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              pd_q;

  // start hunt and configuration capture, cleared by deselect
  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      st_q  <= ST_HUNT;
      idx_q <= '0;
      cfg_q <= '0;
    end else begin
      case (st_q)
        ST_HUNT: if (din) begin
          st_q  <= ST_CFG;
          idx_q <= '0;
        end
        ST_CFG: begin
          cfg_q[idx_q] <= din;
          idx_q        <= idx_q + 1'b1;
          if (idx_q == IW'(CFG_W - 1)) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  // power-down survives deselect, ends at the first edge of a new frame
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
    end else if (!cs_n && st_q == ST_HUNT) begin
      pd_q <= 1'b0;
    end else if (!cs_n && st_q == ST_CFG && idx_q == IW'(F_PUP) && !din) begin
      pd_q <= 1'b1;
    end
  end

  assign cfg_done  = (st_q == ST_DONE);
  assign mux_valid = (st_q == ST_DONE) ||
                     (st_q == ST_CFG && idx_q >= IW'(F_ODD + 1));
  assign sgl  = cfg_q[F_SGL];
  assign odd  = cfg_q[F_ODD];
  assign msbf = cfg_q[F_MSBF];
  assign pup  = cfg_q[F_PUP];
  assign pd   = pd_q;
endmodule

// File: rtl/adc_sar_core.sv
`timescale 1ns/1ps
module adc_sar_core #(
  parameter int NB = 12
) (
  input  logic          sclk,
  input  logic          clr,
  input  logic          active,
  input  logic          force_ones,
  input  logic          comp,
  output logic [NB-1:0] dac,
  output logic [NB-1:0] word,
  output logic          word_valid
);
  localparam int CW = $clog2(NB + 1);

  logic [CW-1:0] cnt_q;
  logic [NB-1:0] sar_q;
  logic [NB-1:0] trial;
  logic          running;
  logic          vld_q;

  assign running = active && (cnt_q < CW'(NB));
  assign trial   = (cnt_q < CW'(NB)) ? (NB'(1) << (CW'(NB - 1) - cnt_q)) : '0;

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      cnt_q <= '0;
      sar_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= running && (cnt_q == CW'(NB - 1)) && !force_ones;
      if (running) begin
        if (comp || force_ones) sar_q <= sar_q | trial;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dac        = sar_q | trial;
  assign word       = sar_q;
  assign word_valid = vld_q;
endmodule

// File: rtl/adc_tx_ser.sv
`timescale 1ns/1ps
module adc_tx_ser #(
  parameter int NB = 12
) (
  input  logic          sclk,
  input  logic          clr,
  input  logic          start,
  input  logic          replay,
  input  logic [NB-1:0] word,
  output logic          dout,
  output logic          oe
);
  localparam int LAST = 2 * NB;
  localparam int PW   = $clog2(LAST + 1);

  logic [PW-1:0] pos_q;
  logic          oe_q;
  logic          dout_q;
  logic          nxt;

  always_comb begin
    int p;
    p   = int'(pos_q);
    nxt = 1'b0;
    if (p >= 1 && p <= NB)                    nxt = word[NB - p];
    else if (replay && p > NB && p < LAST)    nxt = word[p - NB];
  end

  always_ff @(negedge sclk or posedge clr) begin
    if (clr) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
      pos_q  <= '0;
    end else if (!oe_q) begin
      if (start) begin
        oe_q   <= 1'b1;
        dout_q <= 1'b0;
        pos_q  <= PW'(1);
      end
    end else begin
      dout_q <= nxt;
      if (pos_q < PW'(LAST)) pos_q <= pos_q + 1'b1;
    end
  end

  assign dout = dout_q;
  assign oe   = oe_q;
endmodule

// File: rtl/adc_sar_ctl.sv
`timescale 1ns/1ps
module adc_sar_ctl #(
  parameter int NB = 12
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          din,
  input  logic          comp_i,
  output logic          dout_o,
  output logic          dout_oe_o,
  output logic          sample_o,
  output logic          mux_en_o,
  output logic          mux_plus_sel_o,
  output logic          mux_minus_gnd_o,
  output logic [NB-1:0] dac_o,
  output logic [NB-1:0] result_o,
  output logic          res_valid_o,
  output logic          power_down_o
);
  logic clr;
  logic cfg_done, mux_valid, sgl, odd, msbf, pup, pd;
  logic [NB-1:0] word;

  assign clr = cs_n | ~rst_n;

  adc_cfg_rx u_rx (
    .sclk(sclk), .clr(clr), .rst_n(rst_n), .cs_n(cs_n), .din(din),
    .cfg_done(cfg_done), .mux_valid(mux_valid),
    .sgl(sgl), .odd(odd), .msbf(msbf), .pup(pup), .pd(pd)
  );

  adc_sar_core #(.NB(NB)) u_sar (
    .sclk(sclk), .clr(clr), .active(cfg_done), .force_ones(~pup),
    .comp(comp_i), .dac(dac_o), .word(word), .word_valid(res_valid_o)
  );

  adc_tx_ser #(.NB(NB)) u_tx (
    .sclk(sclk), .clr(clr), .start(cfg_done), .replay(pup & ~msbf),
    .word(word), .dout(dout_o), .oe(dout_oe_o)
  );

  assign sample_o        = mux_valid & ~dout_oe_o;
  assign mux_en_o        = mux_valid;
  assign mux_plus_sel_o  = mux_valid & odd;
  assign mux_minus_gnd_o = mux_valid & sgl;
  assign result_o        = word;
  assign power_down_o    = pd;
endmodule

// File: rtl/adc_sar_ctl_chk.sv
`timescale 1ns/1ps
module adc_sar_ctl_chk #(
  parameter int NB = 12
) (
  input logic          sclk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          dout_oe_o,
  input logic          sample_o,
  input logic          mux_en_o,
  input logic          mux_plus_sel_o,
  input logic          mux_minus_gnd_o,
  input logic [NB-1:0] result_o,
  input logic          res_valid_o,
  input logic          power_down_o
);
  // R10: deselect keeps the pad released
  p_hiz_deselect_r10: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !dout_oe_o);

  // R4: tracking never overlaps driving
  p_sample_excl_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    sample_o |-> !dout_oe_o);

  // R11: strobe lasts one cycle
  p_valid_pulse_r11: assert property (@(posedge sclk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R9: no result while powered down
  p_valid_not_pd_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    res_valid_o |-> !power_down_o);

  // R3: selects valid whenever output driven
  p_mux_en_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    dout_oe_o |-> mux_en_o);

  // R3: selects steady during the conversion
  p_mux_hold_r3: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (dout_oe_o && $past(dout_oe_o)) |-> ($stable(mux_plus_sel_o) && $stable(mux_minus_gnd_o)));
endmodule

bind adc_sar_ctl adc_sar_ctl_chk #(.NB(NB)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .dout_oe_o(dout_oe_o),
  .sample_o(sample_o), .mux_en_o(mux_en_o), .mux_plus_sel_o(mux_plus_sel_o),
  .mux_minus_gnd_o(mux_minus_gnd_o), .result_o(result_o),
  .res_valid_o(res_valid_o), .power_down_o(power_down_o)
);

// File: tb/adc_sar_ctl_tb.sv
`timescale 1ns/1ps
module adc_sar_ctl_tb;
  localparam int     NB   = 12;
  localparam longint VREF = 5000;

  logic sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic comp;
  logic dout_o, dout_oe_o, sample_o, mux_en_o, mux_plus_sel_o, mux_minus_gnd_o;
  logic [NB-1:0] dac_o, result_o;
  logic res_valid_o, power_down_o;

  int ch0_mv = 0, ch1_mv = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 sclk = ~sclk;

  adc_sar_ctl #(.NB(NB)) u_dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .comp_i(comp),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .sample_o(sample_o),
    .mux_en_o(mux_en_o), .mux_plus_sel_o(mux_plus_sel_o),
    .mux_minus_gnd_o(mux_minus_gnd_o), .dac_o(dac_o), .result_o(result_o),
    .res_valid_o(res_valid_o), .power_down_o(power_down_o)
  );

  // behavioural analog front end: mux plus threshold compare
  longint vplus, vminus, vdiff;
  always_comb begin
    vplus  = mux_plus_sel_o ? longint'(ch1_mv) : longint'(ch0_mv);
    vminus = mux_minus_gnd_o ? 0 : (mux_plus_sel_o ? longint'(ch0_mv) : longint'(ch1_mv));
    vdiff  = vplus - vminus;
    comp   = (vdiff * 4096 >= longint'(dac_o) * VREF);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ideal(int c0, int c1, bit sgl, bit odd);
    longint p, m, d, q;
    p = odd ? c1 : c0;
    m = sgl ? 0 : (odd ? c0 : c1);
    d = p - m;
    if (d < 0) return 0;
    q = d * 4096 / VREF;
    return (q > 4095) ? 4095 : int'(q);
  endfunction

  function automatic bit exp_bit(int k, int code, bit msbf, bit pup);
    int c;
    c = pup ? code : 4095;
    if (k >= 6 && k <= 17) return c[17 - k];
    if (pup && !msbf && k >= 18 && k <= 28) return c[k - 17];
    return 1'b0;
  endfunction

  // one framed exchange; starts and ends at falling edge + 5 ns
  task automatic run_frame(input string dtag, input int lead0, input bit sgl, input bit odd,
                           input bit msbf, input bit pup, input int c0, input int c1,
                           input int abort_k, input bit after_pd, input bit noise);
    int code, cycles, bad_dk, bad_tk, act_d, exp_d, act_t, exp_t, seen;
    bit hiz_ok, samp_ok, vld_pos_ok, got_valid;
    string ttag;
    code = ideal(c0, c1, sgl, odd);
    bad_dk = 0; bad_tk = 0; act_d = 0; exp_d = 0; act_t = 0; exp_t = 0; seen = -1;
    hiz_ok = 1; samp_ok = 1; vld_pos_ok = 1; got_valid = 0;
    ch0_mv = c0; ch1_mv = c1;
    cs_n = 1'b0; din = 1'b0;
    for (int i = 0; i < lead0; i++) begin
      @(posedge sclk); @(negedge sclk); #5;
      if (dout_oe_o || sample_o) hiz_ok = 0;
    end
    cycles = (abort_k > 0) ? abort_k : 32;
    for (int k = 1; k <= cycles; k++) begin
      case (k)
        1: din = 1'b1;
        2: din = sgl;
        3: din = odd;
        4: din = msbf;
        5: din = pup;
        default: din = noise ? 1'b1 : k[0];
      endcase
      @(posedge sclk); @(negedge sclk); #5;
      if (k == 1 && after_pd)
        chk(power_down_o == 1'b0, "R9", "power-down cleared by new frame", power_down_o, 0);
      if (k < 5 && dout_oe_o) hiz_ok = 0;
      if (sample_o != (k == 3 || k == 4)) samp_ok = 0;
      if (k == 3)
        chk(mux_en_o && mux_plus_sel_o == odd && mux_minus_gnd_o == sgl, "R3", "mux select",
            {mux_en_o, mux_plus_sel_o, mux_minus_gnd_o}, {1'b1, odd, sgl});
      if (k == 5) begin
        chk(dout_oe_o && !dout_o, "R5", "null bit at falling edge 5",
            {dout_oe_o, dout_o}, 2);
        chk(power_down_o == !pup, "R9", "power-down flag after capture", power_down_o, !pup);
      end
      if (k >= 6 && k <= 17 && bad_dk == 0 &&
          (!dout_oe_o || dout_o != exp_bit(k, code, msbf, pup))) begin
        bad_dk = k; act_d = {dout_oe_o, dout_o}; exp_d = {1'b1, exp_bit(k, code, msbf, pup)};
      end
      if (k >= 18 && bad_tk == 0 &&
          (!dout_oe_o || dout_o != exp_bit(k, code, msbf, pup))) begin
        bad_tk = k; act_t = {dout_oe_o, dout_o}; exp_t = {1'b1, exp_bit(k, code, msbf, pup)};
      end
      if (res_valid_o) begin
        got_valid = 1;
        seen = int'(result_o);
        if (k != 17) vld_pos_ok = 0;
      end
    end
    chk(hiz_ok, "R5", "output released before falling edge 5", !hiz_ok, 0);
    if (lead0 > 0)
      chk(hiz_ok && samp_ok, "R1", "leading zeros ignored", !(hiz_ok && samp_ok), 0);
    chk(samp_ok, "R4", "sample window rising 3 to falling 5", !samp_ok, 0);
    if (abort_k == 0) begin
      chk(bad_dk == 0, dtag, $sformatf("result bit at falling edge %0d", bad_dk), act_d, exp_d);
      ttag = !pup ? "R9" : (msbf ? "R7" : "R8");
      chk(bad_tk == 0, ttag, $sformatf("tail bit at falling edge %0d", bad_tk), act_t, exp_t);
      chk(got_valid == pup && vld_pos_ok, "R11", "result strobe position", got_valid, pup);
      if (pup)
        chk(seen == code, "R11", "parallel result", seen, code);
    end
    #1 cs_n = 1'b1;
    #1 chk(!dout_oe_o, "R10", "deselect releases output", dout_oe_o, 0);
    if (!pup && abort_k == 0)
      chk(power_down_o, "R9", "power-down held while deselected", power_down_o, 1);
    din = 1'b0;
    @(negedge sclk); #5;
    @(negedge sclk); #5;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge sclk);
    @(negedge sclk); #5;
    chk(!dout_oe_o, "R12", "reset output enable", dout_oe_o, 0);
    chk(!sample_o && !mux_en_o, "R12", "reset sample/mux", {sample_o, mux_en_o}, 0);
    chk(!res_valid_o, "R12", "reset strobe", res_valid_o, 0);
    chk(!power_down_o, "R12", "reset power-down", power_down_o, 0);
    rst_n = 1'b1;
    @(negedge sclk); #5;
  endtask

  task automatic t_single_ended;
    run_frame("R6", 0, 1, 0, 1, 1, 2500, 0, 0, 0, 0);
    run_frame("R1", 3, 1, 1, 0, 1, 0, 1234, 0, 0, 0);
    run_frame("R6", 0, 1, 0, 1, 1, 5000, 0, 0, 0, 0);
  endtask

  task automatic t_differential;
    run_frame("R6", 1, 0, 0, 0, 1, 4000, 1000, 0, 0, 0);
    run_frame("R6", 0, 0, 1, 1, 1, 4000, 1000, 0, 0, 0);
    run_frame("R6", 2, 0, 1, 0, 1, 700, 3900, 0, 0, 0);
  endtask

  task automatic t_shutdown;
    run_frame("R9", 0, 1, 0, 0, 0, 1000, 0, 0, 0, 0);
    run_frame("R9", 0, 1, 1, 1, 1, 0, 3333, 0, 1, 0);
  endtask

  task automatic t_abort;
    run_frame("R10", 0, 0, 0, 1, 1, 3000, 100, 10, 0, 0);
    run_frame("R10", 0, 0, 0, 1, 1, 3000, 100, 0, 0, 0);
  endtask

  task automatic t_ignored_input;
    run_frame("R2", 0, 1, 0, 1, 1, 777, 0, 0, 0, 1);
    run_frame("R2", 0, 1, 1, 0, 1, 0, 4321, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_single_ended();
    t_differential();
    t_shutdown();
    t_abort();
    t_ignored_input();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule